// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block is a register-mapped controller for two bidirectional 8-bit ports, A and B. A processor reaches it through a plain bus made of an address, write data, a write strobe and read data that follows the address in the same cycle. For every pin the controller drives an output value, an output enable and a pull-down enable. It samples every pin through a two-stage synchronizer and combines the enabled high levels into one wake-up request.

Port A has per-pin wake-up enable and pull-down enable registers. These have no addresses of their own. A bank-select bit in the configuration register maps them over the port A data and direction addresses. Port B uses one global wake-up bit and one global pull-down bit, and both act only on port B input pins. A takeover bit in the configuration register hands port B pin 7 to an external timer-compare signal.

The bus is a control interface, so it has no valid/ready handshake. A write completes in the cycle its strobe is sampled, and a read never stalls. The pad and wake-up signals are plain level outputs.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted, both direction registers, the configuration register and the port A wake-up and pull-down enables clear to 0. As a result, every output enable, pull-down and the wake-up request is 0. Reset does not alter either output data latch.
- R2: The address map is: port A data at 0x0, port B data at 0x1, port A direction at 0x4, port B direction at 0x5, configuration at 0xC. The configuration bits are: bit 0 bank select, bit 1 port B wake-up enable, bit 2 port B pull-down enable, bit 3 general storage, bit 4 timer takeover of port B pin 7. Bits 7..5 always read 0.
- R3: Writing 1 to a direction bit makes that pin an output. Its output enable becomes 1 on the clock edge that samples the write.
- R4: A write to a data address (bank select 0 for port A) always loads the output latch, whatever the pin's direction. The pad output carries the latch value, but it reaches the pin only while the pin's output enable is 1.
- R5: A read of a data address returns the latch bit for output pins and the synchronized pin level for input pins. A pin change appears in the read value after exactly two rising clock edges.
- R6: With bank select 1, address 0x0 reads and writes the port A wake-up enables and address 0x4 reads and writes the port A pull-down enables. In this mode the port A data latch and direction register are neither read nor changed.
- R7: Port A wake-up is enabled per pin. An enabled pin at a synchronized high level requests wake-up whether it is an input or an output.
- R8: Port B wake-up needs configuration bit 1. It is then requested by any synchronized-high port B pin whose direction bit is 0. Output pins never request it.
- R9: A pull-down is driven only on a pin that is currently an input. On port A this needs the pin's own pull-down enable. On port B it needs configuration bit 2.
- R10: With configuration bit 4 set, port B pin 7 outputs the timer-compare input with its output enable forced to 1 and its pull-down off, and it is excluded from wake-up. Reads of bit 7 still follow its direction bit. With bit 4 clear, pin 7 behaves like the other port B pins.
- R11: The wake-up request is the OR of the port A and port B contributions. It is driven from the synchronizer outputs, so it responds to a pin change after two rising edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| pa_pin_i | input | 8 | Port A pin levels |
| pa_out_o | output | 8 | Port A pad output data |
| pa_oe_o | output | 8 | Port A pad output enables |
| pa_pd_o | output | 8 | Port A pad pull-down enables |
| pb_pin_i | input | 8 | Port B pin levels |
| pb_out_o | output | 8 | Port B pad output data |
| pb_oe_o | output | 8 | Port B pad output enables |
| pb_pd_o | output | 8 | Port B pad pull-down enables |
| tmr_cmp_i | input | 1 | Timer-compare level for port B pin 7 |
| wake_o | output | 1 | Combined wake-up request |

## Verification
Register writes reach the output enables, pull-downs and pad data on the single edge that samples the strobe. Read data depends only on the current address and register state, so it is valid in the same cycle. Results that come from pin levels (data reads of input pins and the wake-up request) are due two rising edges after the pin change. The bench changes inputs on the falling edge and samples on a falling edge after the expected number of rising edges. For pin-driven results it also samples one edge early to confirm that the value has not yet changed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register offsets; the data/direction pairing (direction = data + 4) is part of the map
  localparam int OFS_A_DATA = 'h0;
  localparam int OFS_B_DATA = 'h1;
  localparam int OFS_A_DIR  = 'h4;
  localparam int OFS_B_DIR  = 'h5;

  localparam int CFG_BITS = 5;

  // Configuration register, bit 0 at the bottom
  typedef struct packed {
    logic tmr_take;   // bit 4: port B pin 7 driven by timer compare
    logic spare;      // bit 3: storage only
    logic pb_pd_en;   // bit 2: port B pull-downs
    logic pb_wk_en;   // bit 1: port B wake-up
    logic bank_sel;   // bit 0: port A alternate bank
  } cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/gpio_port_a.sv
module gpio_port_a #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bank_sel,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pd,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic         wake
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] wken_q;
  logic [W-1:0] pden_q;

  // Output latch has no reset: its contents survive a reset
  always_ff @(posedge clk) begin
    if (wr_data && !bank_sel) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      wken_q <= '0;
      pden_q <= '0;
    end else begin
      if (wr_dir && !bank_sel) dir_q  <= wdata;
      if (wr_data && bank_sel) wken_q <= wdata;
      if (wr_dir && bank_sel)  pden_q <= wdata;
    end
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
  assign pad_pd  = pden_q & ~dir_q;

  assign rd_data = bank_sel ? wken_q : ((latch_q & dir_q) | (pin_sync & ~dir_q));
  assign rd_dir  = bank_sel ? pden_q : dir_q;

  // Per-pin wake-up does not look at direction
  assign wake = |(wken_q & pin_sync);
endmodule

// File: rtl/gpio_port_b.sv
module gpio_port_b #(
  parameter int W       = 8,
  parameter int TMR_PIN = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  input  logic         wk_en,
  input  logic         pd_en,
  input  logic         tmr_take,
  input  logic         tmr_cmp,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pd,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic         wake
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] wk_hit;

  always_ff @(posedge clk) begin
    if (wr_data) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == TMR_PIN) begin : g_shared
      assign pad_out[i] = tmr_take ? tmr_cmp : latch_q[i];
      assign pad_oe[i]  = tmr_take | dir_q[i];
      assign pad_pd[i]  = pd_en & ~dir_q[i] & ~tmr_take;
      assign wk_hit[i]  = pin_sync[i] & ~dir_q[i] & ~tmr_take;
    end else begin : g_plain
      assign pad_out[i] = latch_q[i];
      assign pad_oe[i]  = dir_q[i];
      assign pad_pd[i]  = pd_en & ~dir_q[i];
      assign wk_hit[i]  = pin_sync[i] & ~dir_q[i];
    end
  end

  assign rd_data = (latch_q & dir_q) | (pin_sync & ~dir_q);
  assign rd_dir  = dir_q;
  assign wake    = wk_en & (|wk_hit);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PORT_W  = 8,
  parameter int CFG_OFS = 'hC,
  parameter int TMR_PIN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pa_pin_i,
  output logic [PORT_W-1:0] pa_out_o,
  output logic [PORT_W-1:0] pa_oe_o,
  output logic [PORT_W-1:0] pa_pd_o,
  input  logic [PORT_W-1:0] pb_pin_i,
  output logic [PORT_W-1:0] pb_out_o,
  output logic [PORT_W-1:0] pb_oe_o,
  output logic [PORT_W-1:0] pb_pd_o,
  input  logic              tmr_cmp_i,
  output logic              wake_o
);
  localparam int PAD_BITS = PORT_W - CFG_BITS;

  cfg_t cfg_q;

  logic hit_a_data, hit_b_data, hit_a_dir, hit_b_dir, hit_cfg;
  assign hit_a_data = (bus_addr == ADDR_W'(OFS_A_DATA));
  assign hit_b_data = (bus_addr == ADDR_W'(OFS_B_DATA));
  assign hit_a_dir  = (bus_addr == ADDR_W'(OFS_A_DIR));
  assign hit_b_dir  = (bus_addr == ADDR_W'(OFS_B_DIR));
  assign hit_cfg    = (bus_addr == ADDR_W'(CFG_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cfg_q <= '0;
    else if (bus_we && hit_cfg) cfg_q <= cfg_t'(bus_wdata[CFG_BITS-1:0]);
  end

  logic [PORT_W-1:0] pa_sync, pb_sync;

  gpio_sync #(.W(PORT_W)) u_sync_a (.clk(clk), .rst_n(rst_n), .din(pa_pin_i), .dout(pa_sync));
  gpio_sync #(.W(PORT_W)) u_sync_b (.clk(clk), .rst_n(rst_n), .din(pb_pin_i), .dout(pb_sync));

  logic [PORT_W-1:0] a_rd_data, a_rd_dir, b_rd_data, b_rd_dir;
  logic              a_wake, b_wake;

  gpio_port_a #(.W(PORT_W)) u_port_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (cfg_q.bank_sel),
    .wr_data  (bus_we && hit_a_data),
    .wr_dir   (bus_we && hit_a_dir),
    .wdata    (bus_wdata),
    .pin_sync (pa_sync),
    .pad_out  (pa_out_o),
    .pad_oe   (pa_oe_o),
    .pad_pd   (pa_pd_o),
    .rd_data  (a_rd_data),
    .rd_dir   (a_rd_dir),
    .wake     (a_wake)
  );

  gpio_port_b #(.W(PORT_W), .TMR_PIN(TMR_PIN)) u_port_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (bus_we && hit_b_data),
    .wr_dir   (bus_we && hit_b_dir),
    .wdata    (bus_wdata),
    .pin_sync (pb_sync),
    .wk_en    (cfg_q.pb_wk_en),
    .pd_en    (cfg_q.pb_pd_en),
    .tmr_take (cfg_q.tmr_take),
    .tmr_cmp  (tmr_cmp_i),
    .pad_out  (pb_out_o),
    .pad_oe   (pb_oe_o),
    .pad_pd   (pb_pd_o),
    .rd_data  (b_rd_data),
    .rd_dir   (b_rd_dir),
    .wake     (b_wake)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_a_data)      bus_rdata = a_rd_data;
    else if (hit_b_data) bus_rdata = b_rd_data;
    else if (hit_a_dir)  bus_rdata = a_rd_dir;
    else if (hit_b_dir)  bus_rdata = b_rd_dir;
    else if (hit_cfg)    bus_rdata = {{PAD_BITS{1'b0}}, cfg_q};
  end

  assign wake_o = a_wake | b_wake;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PORT_W  = 8,
  parameter int CFG_OFS = 'hC,
  parameter int TMR_PIN = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [PORT_W-1:0]   bus_wdata,
  input logic                bus_we,
  input logic [PORT_W-1:0]   bus_rdata,
  input logic [CFG_BITS-1:0] cfg_bits,
  input logic [PORT_W-1:0]   pa_out_o,
  input logic [PORT_W-1:0]   pa_oe_o,
  input logic [PORT_W-1:0]   pb_out_o,
  input logic [PORT_W-1:0]   pb_oe_o,
  input logic [PORT_W-1:0]   pb_pd_o,
  input logic                tmr_cmp_i
);
  logic wr_a_dir, wr_a_data, rd_cfg;
  assign wr_a_dir  = bus_we && (bus_addr == ADDR_W'(OFS_A_DIR));
  assign wr_a_data = bus_we && (bus_addr == ADDR_W'(OFS_A_DATA));
  assign rd_cfg    = (bus_addr == ADDR_W'(CFG_OFS));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_dir && !cfg_bits[0]) |=> (pa_oe_o == $past(bus_wdata)));

  assert_bank_keeps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_data && cfg_bits[0]) |=> $stable(pa_out_o));

  assert_bank_keeps_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_dir && cfg_bits[0]) |=> $stable(pa_oe_o));

  assert_timer_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bits[4] |-> (pb_oe_o[TMR_PIN] && (pb_out_o[TMR_PIN] == tmr_cmp_i) && !pb_pd_o[TMR_PIN]));

  assert_cfg_high_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg |-> ((bus_rdata >> CFG_BITS) == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .CFG_OFS(CFG_OFS), .TMR_PIN(TMR_PIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .cfg_bits(cfg_q),
  .pa_out_o(pa_out_o), .pa_oe_o(pa_oe_o), .pb_out_o(pb_out_o),
  .pb_oe_o(pb_oe_o), .pb_pd_o(pb_pd_o), .tmr_cmp_i(tmr_cmp_i)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_pin_i = '0, pb_pin_i = '0;
  logic [7:0] pa_out_o, pa_oe_o, pa_pd_o, pb_out_o, pb_oe_o, pb_pd_o;
  logic       tmr_cmp_i = 1'b0;
  logic       wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pa_pin_i(pa_pin_i),
    .pa_out_o(pa_out_o), .pa_oe_o(pa_oe_o), .pa_pd_o(pa_pd_o),
    .pb_pin_i(pb_pin_i), .pb_out_o(pb_out_o), .pb_oe_o(pb_oe_o),
    .pb_pd_o(pb_pd_o), .tmr_cmp_i(tmr_cmp_i), .wake_o(wake_o)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Change pins on a falling edge, then let one rising edge pass
  task automatic pins_one_edge(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    pa_pin_i = a; pb_pin_i = b;
    @(negedge clk);
  endtask

  task automatic pins_settle(input logic [7:0] a, input logic [7:0] b);
    pins_one_edge(a, b);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    wr(4'h0, 8'hA5);                  // latch before reset
    wr(4'h4, 8'hFF);
    wr(4'h5, 8'hFF);
    wr(4'hC, 8'h1F);
    do_reset();
    check("R1", "pa_oe after reset", pa_oe_o, 8'h00);
    check("R1", "pb_oe after reset", pb_oe_o, 8'h00);
    check("R1", "pa_pd after reset", pa_pd_o, 8'h00);
    check("R1", "pb_pd after reset", pb_pd_o, 8'h00);
    check("R1", "wake after reset", {7'b0, wake_o}, 8'h00);
    rd(4'hC, v); check("R1", "cfg after reset", v, 8'h00);
    rd(4'h4, v); check("R1", "A dir after reset", v, 8'h00);
    wr(4'h4, 8'hFF);
    rd(4'h0, v); check("R1", "A latch kept over reset", v, 8'hA5);
    check("R1", "A pad data kept", pa_out_o, 8'hA5);
  endtask

  task automatic t_dir_latch();
    logic [7:0] v;
    wr(4'h4, 8'h00);
    wr(4'h0, 8'h3C);
    check("R4", "latch loaded while input, oe", pa_oe_o, 8'h00);
    check("R4", "pad data follows latch", pa_out_o, 8'h3C);
    wr(4'h4, 8'h0F);
    check("R3", "oe after dir write", pa_oe_o, 8'h0F);
    rd(4'h4, v); check("R2", "A dir readback", v, 8'h0F);
    wr(4'h5, 8'hF0);
    check("R3", "pb oe after dir write", pb_oe_o, 8'hF0);
    wr(4'h1, 8'h99);
    check("R4", "pb pad data", pb_out_o, 8'h99);
  endtask

  task automatic t_read_mux();
    logic [7:0] v;
    pins_settle(8'hA0, 8'h0F);
    rd(4'h0, v); check("R5", "A mixed read", v, 8'hAC);
    rd(4'h1, v); check("R5", "B mixed read", v, 8'h9F);
    pins_one_edge(8'h50, 8'h0F);
    rd(4'h0, v); check("R5", "A read one edge after pin change", v, 8'hAC);
    @(negedge clk);
    rd(4'h0, v); check("R5", "A read two edges after pin change", v, 8'h5C);
  endtask

  task automatic t_bank();
    logic [7:0] v;
    wr(4'hC, 8'h01);
    wr(4'h0, 8'h81);
    wr(4'h4, 8'h42);
    rd(4'h0, v); check("R6", "A wake enable readback", v, 8'h81);
    rd(4'h4, v); check("R6", "A pull enable readback", v, 8'h42);
    check("R6", "A latch untouched", pa_out_o, 8'h3C);
    check("R6", "A dir untouched", pa_oe_o, 8'h0F);
    wr(4'hC, 8'h00);
    rd(4'h4, v); check("R6", "A dir back in view", v, 8'h0F);
  endtask

  task automatic t_a_wake();
    pins_settle(8'h00, 8'h00);
    check("R7", "no pins high", {7'b0, wake_o}, 8'h00);
    pins_one_edge(8'h01, 8'h00);   // pin 0 is an output, enabled
    check("R11", "wake not after one edge", {7'b0, wake_o}, 8'h00);
    @(negedge clk);
    check("R7", "output pin wakes", {7'b0, wake_o}, 8'h01);
    pins_settle(8'h02, 8'h00);
    check("R7", "disabled pin no wake", {7'b0, wake_o}, 8'h00);
    pins_settle(8'h80, 8'h00);
    check("R7", "input pin wakes", {7'b0, wake_o}, 8'h01);
    pins_settle(8'h00, 8'h00);
  endtask

  task automatic t_b_wake();
    pins_settle(8'h00, 8'h0F);
    check("R8", "B wake disabled", {7'b0, wake_o}, 8'h00);
    wr(4'hC, 8'h02);
    check("R8", "B inputs wake", {7'b0, wake_o}, 8'h01);
    check("R11", "A and B combined", {7'b0, wake_o}, 8'h01);
    pins_settle(8'h00, 8'hF0);
    check("R8", "B outputs no wake", {7'b0, wake_o}, 8'h00);
    pins_settle(8'h00, 8'h00);
  endtask

  task automatic t_pull();
    wr(4'hC, 8'h04);
    check("R9", "A pull only on inputs", pa_pd_o, 8'h40);
    check("R9", "B pull only on inputs", pb_pd_o, 8'h0F);
    wr(4'hC, 8'h00);
    check("R9", "B pull off", pb_pd_o, 8'h00);
  endtask

  task automatic t_timer();
    logic [7:0] v;
    wr(4'h5, 8'h00);
    wr(4'hC, 8'h16);
    check("R10", "pin7 oe forced", pb_oe_o, 8'h80);
    check("R10", "pin7 pull off", pb_pd_o, 8'h7F);
    @(negedge clk); tmr_cmp_i = 1'b1; #1;
    check("R10", "pin7 follows timer 1", {7'b0, pb_out_o[7]}, 8'h01);
    @(negedge clk); tmr_cmp_i = 1'b0; #1;
    check("R10", "pin7 follows timer 0", {7'b0, pb_out_o[7]}, 8'h00);
    pins_settle(8'h00, 8'h80);
    check("R10", "pin7 excluded from wake", {7'b0, wake_o}, 8'h00);
    rd(4'h1, v); check("R10", "pin7 read follows dir", v, 8'h80);
    wr(4'hC, 8'h06);
    check("R10", "pin7 normal wake", {7'b0, wake_o}, 8'h01);
    check("R10", "pin7 oe released", pb_oe_o, 8'h00);
    pins_settle(8'h00, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    wr(4'hC, 8'hFF);
    rd(4'hC, v); check("R2", "cfg high bits zero", v, 8'h1F);
    wr(4'hC, 8'h08);
    rd(4'hC, v); check("R2", "cfg spare bit stored", v, 8'h08);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_dir_latch();
    t_read_mux();
    t_bank();
    t_a_wake();
    t_b_wake();
    t_pull();
    t_timer();
    t_cfg();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule